// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block generates the reset for a processor. It combines two fault sources into one reset pulse that can be retriggered. The first source is a supply-good flag that already sits in the block's clock domain. The second is an active-low pushbutton request, which arrives from outside the clock domain. Reset stays asserted while either source reports a fault. After both sources clear, reset stays asserted for a programmable number of clock cycles.

A new fault during that hold window cancels the countdown. The full hold then restarts once the fault clears. The pushbutton needs no debouncer of its own, for two reasons. First, a low level must persist for a qualification window before it counts as a request. Second, the hold window absorbs contact bounce after release. The reset appears on two outputs, one active-high and one active-low, and both switch on the same clock edge.

Top module: `supv_reset_gen`

## Requirements
- R1: While `rstN` is low, `resetHi` is 1 and `resetLo` is 0. The first hold window starts at the first clock edge after `rstN` rises.
- R2: If `supplyOk` is sampled low at a clock edge, both outputs show reset from that edge on. They stay asserted for as long as `supplyOk` remains low.
- R3: Suppose the last fault to clear is the supply, and `supplyOk` is first sampled high at edge E. Then reset releases at edge E+HOLD_CYCLES. Counted on negative-edge samples taken after E, reset is high for exactly HOLD_CYCLES samples.
- R4: If `supplyOk` goes low again before the hold window ends, the countdown is discarded. A full HOLD_CYCLES window is measured again from the edge at which `supplyOk` is next sampled high.
- R5: Suppose `manualRstN` is driven low before edge F0 and stays low for at least MR_QUAL_CYCLES cycles. Then reset asserts at edge F0+MR_QUAL_CYCLES+2: two cycles for synchronisation, plus the qualification window. MR_QUAL_CYCLES must be below MR_MIN_CYCLES, so every pulse of the minimum legal width is accepted.
- R6: A low pulse on `manualRstN` shorter than MR_QUAL_CYCLES cycles has no effect. This covers a train of such pulses, whether it arrives while the outputs are released or during a hold window that is already counting.
- R7: Suppose a qualified manual request is the last fault to clear, and `manualRstN` is driven high before edge G0. Then reset releases at edge G0+HOLD_CYCLES+3.
- R8: `resetLo` is the exact complement of `resetHi` at every sample.
- R9: When the supply fault and the manual request overlap, reset stays asserted without a gap. The hold window is timed from whichever of the two clears last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; hold and qualification times are counted in its cycles |
| rstN | input | 1 | Active-low reset of the block's own logic |
| supplyOk | input | 1 | Synchronous supply-good flag, 1 when the supply is above threshold |
| manualRstN | input | 1 | Asynchronous active-low reset request; treat an undriven pin as 1 (pull-up) |
| resetHi | output | 1 | Reset to the processor, active-high |
| resetLo | output | 1 | Reset to the processor, active-low |

## Verification
The bench measures the length of every reset episode in cycles. The hardest cases are listed here with the failure each one exposes.
- A supply dip in the middle of a hold window: a design that only pauses its counter would release early.
- Manual pulses one cycle shorter than, and exactly equal to, the qualification window: an off-by-one in the qualifier either spawns an extra episode or misses a legal press.
- Short bounce pulses during a hold: a qualifier that cleared the hold counter directly would stretch the episode.
- Both overlap orders of the supply fault and a manual request: a design that timed the hold from the first source to clear would release too early.

// File: rtl/supv_reset_pkg.sv
package supv_reset_pkg;

  // Sequencer states; only ST_RUN leaves the processor out of reset.
  typedef enum logic [1:0] {
    ST_FAULT = 2'd0,
    ST_HOLD  = 2'd1,
    ST_RUN   = 2'd2
  } supvState_t;

  // Strobes from the sequencer to the hold counter.
  typedef struct packed {
    logic clrHold;
    logic incHold;
  } holdCtl_t;

endpackage

// File: rtl/supv_reset_dp.sv
module supv_reset_dp
  import supv_reset_pkg::*;
#(
  parameter int HOLD_CYCLES    = 40_000_000,
  parameter int MR_QUAL_CYCLES = 64,
  parameter int SYNC_STAGES    = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     supplyOk,
  input  logic     manualRstN,
  input  holdCtl_t ctl,
  output logic     fault,
  output logic     holdLast
);

  localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);
  localparam int QUAL_W = $clog2(MR_QUAL_CYCLES + 1);

  // The synchroniser powers up in the released state, as a pulled-up pin would read.
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   mrSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], manualRstN};
  end

  assign mrSync = syncQ[SYNC_STAGES-1];

  // Qualifier: counts consecutive low samples and saturates at the window size.
  logic [QUAL_W-1:0] qualCnt;
  logic              mrActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                qualCnt <= '0;
    else if (mrSync)                          qualCnt <= '0;
    else if (qualCnt != QUAL_W'(MR_QUAL_CYCLES)) qualCnt <= qualCnt + 1'b1;
  end

  assign mrActive = (qualCnt == QUAL_W'(MR_QUAL_CYCLES));
  assign fault    = !supplyOk || mrActive;

  // Hold counter, driven only by the sequencer strobes.
  logic [HOLD_W-1:0] holdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            holdCnt <= '0;
    else if (ctl.clrHold) holdCnt <= '0;
    else if (ctl.incHold) holdCnt <= holdCnt + 1'b1;
  end

  assign holdLast = (holdCnt == HOLD_W'(HOLD_CYCLES - 1));

endmodule

// File: rtl/supv_reset_ctl.sv
module supv_reset_ctl
  import supv_reset_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     fault,
  input  logic     holdLast,
  output holdCtl_t ctl,
  output logic     resetHi,
  output logic     resetLo
);

  supvState_t state, stateNext;

  always_comb begin
    stateNext   = state;
    ctl.clrHold = 1'b0;
    ctl.incHold = 1'b0;
    unique case (state)
      ST_FAULT: begin
        ctl.clrHold = 1'b1;
        if (!fault) stateNext = ST_HOLD;
      end
      ST_HOLD: begin
        if (fault) begin
          ctl.clrHold = 1'b1;
          stateNext   = ST_FAULT;
        end else begin
          ctl.incHold = 1'b1;
          if (holdLast) stateNext = ST_RUN;
        end
      end
      ST_RUN: begin
        ctl.clrHold = 1'b1;
        if (fault) stateNext = ST_FAULT;
      end
      default: begin
        ctl.clrHold = 1'b1;
        stateNext   = ST_FAULT;
      end
    endcase
  end

  // Both polarities come from their own flops and are loaded from the same next state.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_FAULT;
      resetHi <= 1'b1;
      resetLo <= 1'b0;
    end else begin
      state   <= stateNext;
      resetHi <= (stateNext != ST_RUN);
      resetLo <= (stateNext == ST_RUN);
    end
  end

endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen
  import supv_reset_pkg::*;
#(
  parameter int HOLD_CYCLES    = 40_000_000,
  parameter int MR_MIN_CYCLES  = 100,
  parameter int MR_QUAL_CYCLES = 64,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyOk,
  input  logic manualRstN,
  output logic resetHi,
  output logic resetLo
);

  generate
    if (MR_QUAL_CYCLES >= MR_MIN_CYCLES || MR_QUAL_CYCLES < 1)
      $error("qualification window must be 1..MR_MIN_CYCLES-1");
    if (HOLD_CYCLES < 2)
      $error("hold time must be at least two cycles");
    if (SYNC_STAGES < 2)
      $error("synchroniser needs at least two stages");
  endgenerate

  holdCtl_t ctl;
  logic     fault;
  logic     holdLast;

  supv_reset_dp #(
    .HOLD_CYCLES   (HOLD_CYCLES),
    .MR_QUAL_CYCLES(MR_QUAL_CYCLES),
    .SYNC_STAGES   (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .supplyOk  (supplyOk),
    .manualRstN(manualRstN),
    .ctl       (ctl),
    .fault     (fault),
    .holdLast  (holdLast)
  );

  supv_reset_ctl u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .fault   (fault),
    .holdLast(holdLast),
    .ctl     (ctl),
    .resetHi (resetHi),
    .resetLo (resetLo)
  );

endmodule

// File: rtl/supv_reset_gen_chk.sv
module supv_reset_gen_chk #(
  parameter int HOLD_CYCLES    = 40_000_000,
  parameter int MR_QUAL_CYCLES = 64
) (
  input logic clk,
  input logic rstN,
  input logic supplyOk,
  input logic manualRstN,
  input logic resetHi,
  input logic resetLo
);

  localparam int QW = $clog2(HOLD_CYCLES + 2);
  localparam int MW = $clog2(MR_QUAL_CYCLES + 4);

  // Consecutive cycles with the supply good, saturating just past the hold time.
  logic [QW-1:0] quietCnt;
  // Consecutive cycles with the pushbutton pin low, saturating.
  logic [MW-1:0] lowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quietCnt <= '0;
      lowCnt   <= '0;
    end else begin
      if (!supplyOk)                           quietCnt <= '0;
      else if (quietCnt != QW'(HOLD_CYCLES + 1)) quietCnt <= quietCnt + 1'b1;
      if (manualRstN)                          lowCnt <= '0;
      else if (lowCnt != MW'(MR_QUAL_CYCLES + 3)) lowCnt <= lowCnt + 1'b1;
    end
  end

  // R1: the first cycle out of reset still shows the processor held in reset
  p_reset_state_r1: assert property (@(posedge clk) $rose(rstN) |-> resetHi && !resetLo);

  // R2: a supply fault asserts reset on the following cycle
  p_supply_fault_r2: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> resetHi);

  // R3 and R4: release only after a full quiet window on the supply
  p_release_after_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(resetHi) |-> quietCnt >= QW'(HOLD_CYCLES));

  // R5: a request held past synchronisation and qualification keeps reset asserted
  p_manual_held_r5: assert property (@(posedge clk) disable iff (!rstN)
    lowCnt == MW'(MR_QUAL_CYCLES + 3) |-> resetHi);

  // R8: the two output flops always disagree
  p_complement_r8: assert property (@(posedge clk) disable iff (!rstN)
    resetHi != resetLo);

endmodule

bind supv_reset_gen supv_reset_gen_chk #(
  .HOLD_CYCLES   (HOLD_CYCLES),
  .MR_QUAL_CYCLES(MR_QUAL_CYCLES)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .supplyOk  (supplyOk),
  .manualRstN(manualRstN),
  .resetHi   (resetHi),
  .resetLo   (resetLo)
);

// File: tb/supv_reset_gen_test.sv
`timescale 1ns/1ps
module supv_reset_gen_test;

  localparam int HOLD = 20;
  localparam int QUAL = 4;
  localparam int MINW = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyOk = 1'b1;
  logic manualRstN = 1'b1;
  logic resetHi, resetLo;

  int checks = 0;
  int errors = 0;
  int compBad = 0;
  bit finished = 1'b0;

  typedef struct {
    string tag;
    int    cycles;
  } episode_t;
  episode_t expQ[$];

  always #2.5 clk = ~clk;

  supv_reset_gen #(
    .HOLD_CYCLES   (HOLD),
    .MR_MIN_CYCLES (MINW),
    .MR_QUAL_CYCLES(QUAL)
  ) uut (
    .clk       (clk),
    .rstN      (rstN),
    .supplyOk  (supplyOk),
    .manualRstN(manualRstN),
    .resetHi   (resetHi),
    .resetLo   (resetLo)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_episode(string tag, int cycles);
    episode_t e;
    e.tag = tag;
    e.cycles = cycles;
    expQ.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: measure each high episode of resetHi in negedge samples and compare.
  initial begin
    int run;
    run = 0;
    wait (rstN);
    forever begin
      @(negedge clk);
      if (resetLo !== ~resetHi) compBad++;
      if (resetHi === 1'b1) run++;
      else if (run > 0) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R6 unexpected reset episode", run, 0);
        end else begin
          episode_t e;
          e = expQ.pop_front();
          check(run == e.cycles, e.tag, run, e.cycles);
        end
        run = 0;
      end
    end
  end

  // Supply dip of d cycles, driven low before edge E0.
  task automatic supply_dip(int d, string tag);
    expect_episode(tag, d + HOLD);
    @(negedge clk) supplyOk = 1'b0;
    @(negedge clk);
    check(resetHi === 1'b1 && resetLo === 1'b0, "R2 reset one cycle after dip", resetHi, 1);
    idle(d - 1);
    supplyOk = 1'b1;
    idle(HOLD + d + 10);
  endtask

  // Manual press of len cycles starting from the released state.
  task automatic manual_press(int len, string tag);
    if (len >= QUAL) expect_episode(tag, len + HOLD - QUAL + 1);
    @(negedge clk) manualRstN = 1'b0;
    for (int k = 1; k <= len; k++) begin
      @(negedge clk);
      if (len >= QUAL + 3 && k == QUAL + 2)
        check(resetHi === 1'b0, "R5 no reset before qualification", resetHi, 0);
      if (len >= QUAL + 3 && k == QUAL + 3)
        check(resetHi === 1'b1, "R5 reset after qualification", resetHi, 1);
      if (k == len) manualRstN = 1'b1;
    end
    idle(HOLD + len + 10);
  endtask

  initial begin
    // R1: reset state
    idle(3);
    check(resetHi === 1'b1, "R1 resetHi during block reset", resetHi, 1);
    check(resetLo === 1'b0, "R1 resetLo during block reset", resetLo, 0);
    expect_episode("R1 R3 first hold after block reset", HOLD);
    @(negedge clk) rstN = 1'b1;
    idle(HOLD + 10);
    check(resetHi === 1'b0, "R3 released after first hold", resetHi, 0);

    // R2 R3: plain supply dips of two lengths
    supply_dip(5, "R3 hold after 5-cycle dip");
    supply_dip(1, "R3 hold after 1-cycle dip");

    // R4: dip during the hold restarts the full window
    expect_episode("R4 retriggered hold", 3 + (HOLD - 2) + 2 + HOLD);
    @(negedge clk) supplyOk = 1'b0;
    idle(3);  supplyOk = 1'b1;
    idle(HOLD - 2); supplyOk = 1'b0;
    idle(2);  supplyOk = 1'b1;
    idle(HOLD + 15);

    // R5 R7: long press, minimum legal press, and exact qualification boundary
    manual_press(10, "R7 hold after 10-cycle press");
    manual_press(MINW, "R5 minimum-width press");
    manual_press(QUAL, "R5 press equal to qualification window");

    // R6: press one cycle short, then a bounce train, all ignored
    manual_press(QUAL - 1, "R6 short press");
    for (int b = 1; b < QUAL; b++) begin
      @(negedge clk) manualRstN = 1'b0;
      idle(b);
      manualRstN = 1'b1;
      idle(2);
    end
    idle(10);
    check(resetHi === 1'b0, "R6 short pulses left reset released", resetHi, 0);

    // R6 R7: bounce during a hold does not stretch it
    expect_episode("R6 bounce during hold", 8 + HOLD - QUAL + 1);
    @(negedge clk) manualRstN = 1'b0;
    idle(8); manualRstN = 1'b1;
    idle(5);
    for (int b = 0; b < 3; b++) begin
      manualRstN = 1'b0; idle(2);
      manualRstN = 1'b1; idle(2);
    end
    idle(HOLD + 10);

    // R9: supply clears first, manual request released last
    expect_episode("R9 manual clears last", 20 + HOLD + 3);
    @(negedge clk) supplyOk = 1'b0;
    idle(3);  manualRstN = 1'b0;
    idle(7);  supplyOk = 1'b1;
    idle(10); manualRstN = 1'b1;
    idle(HOLD + 15);

    // R9: manual released first, supply clears last
    expect_episode("R9 supply clears last", 18 + HOLD - QUAL);
    @(negedge clk) manualRstN = 1'b0;
    idle(10); supplyOk = 1'b0;
    idle(4);  manualRstN = 1'b1;
    idle(6);  supplyOk = 1'b1;
    idle(HOLD + 15);

    check(expQ.size() == 0, "R3 all expected episodes observed", expQ.size(), 0);
    check(compBad == 0, "R8 outputs complementary", compBad, 0);
    finished = 1'b1;
  end

  initial begin
    for (int i = 0; i < 200000 && !finished; i++) @(posedge clk);
    if (!finished) check(1'b0, "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule